// File: doc/BRIEF.md
# Reload-and-Compare PWM Timer

This block is a free-running up-counter that produces one pulse-width-modulated output. Instead of counting from zero to a period limit, the counter climbs from a programmable reload value to the all-ones value. When it rolls past all-ones it picks up the reload value again and drives the output to its active level. A compare register marks the point in the climb where the output returns to its inactive level. The reload value therefore sets the period, and the distance from the reload value to the compare value sets the active time.

Software controls the block through one shared data bus and four write strobes. One strobe writes the reload register, one the compare register, one the counter itself, and one a small control word. The control word holds the run bit, the polarity-invert bit, the compare enable, and an optional power-of-two tick prescaler. Reload and compare writes take effect at once, with no shadow copy, so a period in progress can mix old and new settings. Starting the timer presets the counter two ticks below rollover, so the first active edge arrives quickly. Stopping freezes the counter on the spot.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset the counter reads 0, the running and inverted status outputs are 0, and `pwmOut` is 0.
- R2: A control write with the run bit (`wrData[0]`) set while stopped presets the counter to 0xFFFFFFFE and sets `running`. With no prescaler, `pwmOut` reaches its active level two clocks later.
- R3: With load `L` and match `M` (L <= M < 0xFFFFFFFF) and compare enabled (`wrData[2]` of the control word), the output is active for `M-L+1` ticks and inactive for `0xFFFFFFFF-M` ticks in every period.
- R4: On the tick where the counter holds 0xFFFFFFFF, the counter takes the load value and the output goes active.
- R5: With compare disabled, the output stays active once it has gone active.
- R6: A control write with the run bit clear stops the counter in the same cycle, without completing the period. While stopped, the counter holds its value, `running` reads 0, and `pwmOut` rests at the inactive level.
- R7: The invert bit (`wrData[1]`) swaps the levels. The active level is 1 when invert is 0 and 0 when invert is 1, and `inverted` reports the bit.
- R8: A control write that leaves the run bit set while running does not change the invert bit.
- R9: Load and match writes while running act at once on the running counter. The period after the next reload uses the new values.
- R10: With the prescaler enable (`wrData[3]`) set, the counter advances once every `2^(ratio+1)` clocks, where `ratio` is `wrData[6:4]`. With the enable clear, the counter advances every clock.
- R11: A counter write loads `wrData` straight into the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrLoad | input | 1 | Write strobe for the reload register |
| wrMatch | input | 1 | Write strobe for the compare register |
| wrCount | input | 1 | Write strobe for the counter |
| wrCtrl | input | 1 | Write strobe for the control word (bit0 run, bit1 invert, bit2 compare enable, bit3 prescaler enable, bits 6:4 ratio) |
| wrData | input | CNT_W | Write data shared by all strobes |
| countVal | output | CNT_W | Present counter value |
| running | output | 1 | Run status |
| inverted | output | 1 | Polarity status |
| pwmOut | output | 1 | PWM output pin |

## Verification
The bench follows the counter through the start preset and the first rollover. A design that skipped the preset, or reloaded one tick late, would show the first active edge in the wrong cycle or read the wrong counter value after rollover. It stops the timer and compares the counter against its value just before the stop edge; a design that let one more tick through would fail that check. It also tries to flip polarity while running, turns compare off, and rewrites load and match mid-period. These cases catch a design that applies polarity live, that still clears on compare, or that shadows register writes until the next period. Random periods, duty values, polarities and prescale ratios check the high and low lengths against `M-L+1` and `0xFFFFFFFF-M`, each multiplied by the prescale divisor.

// File: rtl/reload_pwm_pkg.sv
package reload_pwm_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadWr;
    logic matchWr;
    logic countWr;
    logic startPulse;
    logic tick;
    logic cmpEn;
  } dpCmd_t;

  // control word layout, LSB first: run, invert, cmpEn, preEn, ratio[2:0]
  typedef struct packed {
    logic [2:0] ratio;
    logic       preEn;
    logic       cmpEn;
    logic       invert;
    logic       run;
  } ctrlWord_t;

  localparam int CTRL_W = $bits(ctrlWord_t);
  localparam int RATIO_W = 3;

endpackage

// File: rtl/reload_pwm_ctrl.sv
module reload_pwm_ctrl
  import reload_pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrLoad,
  input  logic      wrMatch,
  input  logic      wrCount,
  input  logic      wrCtrl,
  input  ctrlWord_t ctrlIn,
  output dpCmd_t    cmd,
  output logic      running,
  output logic      inverted
);

  localparam int DIV_W = 1 << RATIO_W;

  logic               runQ;
  logic               invQ;
  logic               cmpEnQ;
  logic               preEnQ;
  logic [RATIO_W-1:0] ratioQ;
  logic [DIV_W-1:0]   preCnt;
  logic [DIV_W-1:0]   divMask;
  logic               startReq;
  logic               stopReq;
  logic               preHit;
  logic               tick;

  assign startReq = wrCtrl && ctrlIn.run && !runQ;
  assign stopReq  = wrCtrl && !ctrlIn.run && runQ;

  // divide by 2^(ratio+1): terminal count is (2 << ratio) - 1
  assign divMask = (DIV_W'(2) << ratioQ) - DIV_W'(1);
  assign preHit  = !preEnQ || (preCnt >= divMask);
  assign tick    = runQ && !stopReq && preHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      invQ   <= 1'b0;
      cmpEnQ <= 1'b0;
      preEnQ <= 1'b0;
      ratioQ <= '0;
    end else if (wrCtrl) begin
      runQ   <= ctrlIn.run;
      if (!runQ) invQ <= ctrlIn.invert;   // polarity locked while running
      cmpEnQ <= ctrlIn.cmpEn;
      preEnQ <= ctrlIn.preEn;
      ratioQ <= ctrlIn.ratio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (startReq || !runQ || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end

  always_comb begin
    cmd.loadWr     = wrLoad;
    cmd.matchWr    = wrMatch;
    cmd.countWr    = wrCount;
    cmd.startPulse = startReq;
    cmd.tick       = tick;
    cmd.cmpEn      = cmpEnQ;
  end

  assign running  = runQ;
  assign inverted = invQ;

endmodule

// File: rtl/reload_pwm_dp.sv
module reload_pwm_dp
  import reload_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] loadQ,
  output logic             rawActive
);

  localparam logic [CNT_W-1:0] TOP_VAL   = '1;
  localparam logic [CNT_W-1:0] PRESET_VAL = TOP_VAL - CNT_W'(1);

  logic [CNT_W-1:0] matchQ;
  logic             atTop;
  logic             atMatch;

  assign atTop   = (countQ == TOP_VAL);
  assign atMatch = (countQ == matchQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadQ  <= '0;
      matchQ <= '0;
    end else begin
      if (cmd.loadWr)  loadQ  <= wrData;
      if (cmd.matchWr) matchQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (cmd.startPulse) begin
      countQ <= PRESET_VAL;
    end else if (cmd.countWr) begin
      countQ <= wrData;
    end else if (cmd.tick) begin
      countQ <= atTop ? loadQ : countQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawActive <= 1'b0;
    end else if (cmd.startPulse) begin
      rawActive <= 1'b0;
    end else if (!cmd.countWr && cmd.tick) begin
      if (atTop)                    rawActive <= 1'b1;
      else if (cmd.cmpEn && atMatch) rawActive <= 1'b0;
    end
  end

endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer
  import reload_pwm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrLoad,
  input  logic             wrMatch,
  input  logic             wrCount,
  input  logic             wrCtrl,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] countVal,
  output logic             running,
  output logic             inverted,
  output logic             pwmOut
);

  dpCmd_t           dpCmd;
  ctrlWord_t        ctrlIn;
  logic [CNT_W-1:0] loadQ;
  logic             rawActive;

  assign ctrlIn = ctrlWord_t'(wrData[CTRL_W-1:0]);

  reload_pwm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrLoad   (wrLoad),
    .wrMatch  (wrMatch),
    .wrCount  (wrCount),
    .wrCtrl   (wrCtrl),
    .ctrlIn   (ctrlIn),
    .cmd      (dpCmd),
    .running  (running),
    .inverted (inverted)
  );

  reload_pwm_dp #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (dpCmd),
    .wrData    (wrData),
    .countQ    (countVal),
    .loadQ     (loadQ),
    .rawActive (rawActive)
  );

  // stopped: rest at the inactive level of the selected polarity
  assign pwmOut = running ? (rawActive ^ inverted) : inverted;

endmodule

// File: rtl/reload_pwm_chk.sv
module reload_pwm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrCount,
  input logic             wrCtrl,
  input logic [CNT_W-1:0] wrData,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] loadQ,
  input logic             tick,
  input logic             running,
  input logic             inverted,
  input logic             pwmOut
);

  localparam logic [CNT_W-1:0] TOP_VAL = '1;

  // R2
  start_preset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && wrCtrl && wrData[0]) |=> (running && countVal == (TOP_VAL - CNT_W'(1))));

  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !wrCount && !wrCtrl) |=> $stable(countVal));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && tick && countVal == TOP_VAL && !wrCount) |=> (countVal == $past(loadQ)));

  // R4
  overflow_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && tick && countVal == TOP_VAL && !wrCount && !wrCtrl) |=> (pwmOut != inverted));

  // R8
  invert_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && wrCtrl && wrData[0]) |=> $stable(inverted));

endmodule

bind reload_pwm_timer reload_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrCount  (wrCount),
  .wrCtrl   (wrCtrl),
  .wrData   (wrData),
  .countVal (countVal),
  .loadQ    (loadQ),
  .tick     (dpCmd.tick),
  .running  (running),
  .inverted (inverted),
  .pwmOut   (pwmOut)
);

// File: tb/reload_pwm_timer_tb.sv
`timescale 1ns/1ps
module reload_pwm_timer_tb;

  localparam int W = 32;
  localparam logic [W-1:0] MAXV = '1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrLoad = 1'b0, wrMatch = 1'b0, wrCount = 1'b0, wrCtrl = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] countVal;
  logic         running, inverted, pwmOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  reload_pwm_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .wrLoad(wrLoad), .wrMatch(wrMatch),
    .wrCount(wrCount), .wrCtrl(wrCtrl), .wrData(wrData),
    .countVal(countVal), .running(running), .inverted(inverted), .pwmOut(pwmOut)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ctrlW(input logic run, input logic inv, input logic cmp,
                                         input logic pre, input logic [2:0] ratio);
    return {{(W-7){1'b0}}, ratio, pre, cmp, inv, run};
  endfunction

  function automatic int divOf(input logic pre, input logic [2:0] ratio);
    return pre ? (2 << ratio) : 1;
  endfunction

  function automatic int expHigh(input int d, input int dv);
    return d * dv;
  endfunction

  function automatic int expLow(input int p, input int d, input int dv);
    return (p - d) * dv;
  endfunction

  // which: 0 load, 1 match, 2 count, 3 ctrl
  task automatic wr(input int which, input logic [W-1:0] d);
    @(negedge clk);
    wrData = d;
    case (which)
      0: wrLoad = 1'b1;
      1: wrMatch = 1'b1;
      2: wrCount = 1'b1;
      default: wrCtrl = 1'b1;
    endcase
    @(negedge clk);
    wrLoad = 1'b0; wrMatch = 1'b0; wrCount = 1'b0; wrCtrl = 1'b0;
  endtask

  task automatic setup(input int p, input int d, input logic inv, input logic cmp,
                       input logic pre, input logic [2:0] ratio, output logic [W-1:0] ld);
    ld = MAXV - W'(p) + W'(1);
    wr(3, ctrlW(1'b0, 1'b0, 1'b0, 1'b0, 3'd0));
    wr(0, ld);
    wr(1, ld + W'(d) - W'(1));
    wr(3, ctrlW(1'b1, inv, cmp, pre, ratio));
  endtask

  // lengths of one full active phase and the following inactive phase
  task automatic measure(input logic act, output int hi, output int lo);
    int guard;
    guard = 0;
    while (pwmOut == act && guard < 5000) begin @(negedge clk); guard++; end
    while (pwmOut != act && guard < 10000) begin @(negedge clk); guard++; end
    hi = 0;
    while (pwmOut == act && hi < 5000) begin hi++; @(negedge clk); end
    lo = 0;
    while (pwmOut != act && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] ld;
    logic [W-1:0] frozen;
    int hi, lo, lows;
    int unsigned seedV;
    seedV = 32'd20240611;
    void'($urandom(seedV));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count", countVal, '0);
    chk("R1 running", W'(running), '0);
    chk("R1 inverted", W'(inverted), '0);
    chk("R1 pwm", W'(pwmOut), '0);

    // R11 direct counter write
    wr(2, 32'h1234_5678);
    chk("R11 count write", countVal, 32'h1234_5678);

    // R2 start preset and first rollover, R4 reload value
    setup(8, 3, 1'b0, 1'b1, 1'b0, 3'd0, ld);
    chk("R2 preset", countVal, MAXV - W'(1));
    chk("R2 running", W'(running), W'(1));
    chk("R2 pwm before rollover", W'(pwmOut), '0);
    @(negedge clk);
    chk("R2 count at top", countVal, MAXV);
    chk("R2 pwm still idle", W'(pwmOut), '0);
    @(negedge clk);
    chk("R2 pwm active", W'(pwmOut), W'(1));
    chk("R4 reload", countVal, ld);
    measure(1'b1, hi, lo);
    chk("R3 high", W'(hi), W'(expHigh(3, 1)));
    chk("R3 low", W'(lo), W'(expLow(8, 3, 1)));

    // R6 immediate stop
    @(negedge clk);
    frozen = countVal;
    wrData = ctrlW(1'b0, 1'b0, 1'b1, 1'b0, 3'd0);
    wrCtrl = 1'b1;
    @(negedge clk);
    wrCtrl = 1'b0;
    chk("R6 frozen at stop", countVal, frozen);
    chk("R6 running low", W'(running), '0);
    chk("R6 idle level", W'(pwmOut), '0);
    repeat (5) @(negedge clk);
    chk("R6 still frozen", countVal, frozen);

    // R7 polarity
    wr(3, ctrlW(1'b0, 1'b1, 1'b0, 1'b0, 3'd0));
    chk("R7 inverted status", W'(inverted), W'(1));
    chk("R7 inverted idle", W'(pwmOut), W'(1));
    setup(10, 4, 1'b1, 1'b1, 1'b0, 3'd0, ld);
    measure(1'b0, hi, lo);
    chk("R7 active-low high", W'(hi), W'(expHigh(4, 1)));
    chk("R7 active-low low", W'(lo), W'(expLow(10, 4, 1)));

    // R8 polarity change while running is ignored
    wr(3, ctrlW(1'b1, 1'b0, 1'b1, 1'b0, 3'd0));
    chk("R8 inverted kept", W'(inverted), W'(1));
    measure(1'b0, hi, lo);
    chk("R8 still active-low", W'(hi), W'(expHigh(4, 1)));

    // R5 compare disabled
    setup(6, 2, 1'b0, 1'b0, 1'b0, 3'd0, ld);
    repeat (3) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 30; i++) begin
      if (pwmOut !== 1'b1) lows++;
      @(negedge clk);
    end
    chk("R5 stays active", W'(lows), '0);

    // R9 live updates
    setup(20, 5, 1'b0, 1'b1, 1'b0, 3'd0, ld);
    measure(1'b1, hi, lo);
    chk("R9 base high", W'(hi), W'(5));
    wr(1, ld + W'(11));
    measure(1'b1, hi, lo);
    chk("R9 new match high", W'(hi), W'(12));
    chk("R9 new match low", W'(lo), W'(8));
    ld = MAXV - W'(30) + W'(1);
    wr(0, ld);
    wr(1, ld + W'(6));
    measure(1'b1, hi, lo);
    chk("R9 new load high", W'(hi), W'(7));
    chk("R9 new load low", W'(lo), W'(23));

    // R10 prescaler directed
    setup(4, 1, 1'b0, 1'b1, 1'b1, 3'd2, ld);
    measure(1'b1, hi, lo);
    chk("R10 prescaled high", W'(hi), W'(expHigh(1, 8)));
    chk("R10 prescaled low", W'(lo), W'(expLow(4, 1, 8)));

    // R3 / R10 random
    for (int n = 0; n < 10; n++) begin
      int p, d, dv;
      logic inv, pre;
      logic [2:0] ratio;
      p     = $urandom_range(20, 2);
      d     = $urandom_range(p - 1, 1);
      inv   = 1'($urandom_range(1, 0));
      pre   = 1'($urandom_range(1, 0));
      ratio = 3'($urandom_range(2, 0));
      dv    = divOf(pre, ratio);
      setup(p, d, inv, 1'b1, pre, ratio, ld);
      measure(~inv, hi, lo);
      chk("R3 random high", W'(hi), W'(expHigh(d, dv)));
      chk("R10 random low", W'(lo), W'(expLow(p, d, dv)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule